// File: doc/BRIEF.md
# Cascaded Configuration Enumerator

This block models a row of identical coprocessor control units that share one data bus. Each unit holds three items: a pending control state, a configuration word and an active-low full flag. Bus traffic uses two cycles. An instruction cycle places a control state on the bus, and a later execute cycle applies the bus data to that control state. A configuration write goes to every unit at once. A page-number write, in contrast, lands on only one unit, so units that were all reset to identical settings can each be given a unique page number.

Position along a daisy chain sets the priority of each unit, and unit 0 has the highest. Each unit tells the next one down whether every unit above it, including itself, is full. The unit that sees all units above it full while its own flag is still empty is the only target of a page-number write. That unit then marks itself full, so the next page-number write moves down the chain. A broadcast clear control state returns every flag to empty. The chain output at the bottom indicates when the whole array is full.

Top module: `cfg_enum_array`

## Requirements
- R1: While reset is low, and directly after it, each configuration word equals 0x0200_0000 (only bit 25, the lowest-device marker, set). All full flags are high (empty), every hardware-mode flag is low, and `allFull` is low.
- R2: A strobed cycle with `addrValidN` high and data bit 13 low loads data bits 11..0 into the pending control state. If bit 13 is high in such a cycle, the pending control state does not change.
- R3: A strobed cycle with `addrValidN` low while the pending control state is 0x006 writes all 32 data bits into the configuration word of every unit.
- R4: The execute cycle of a 0x006 write sets a unit's hardware-mode flag when data bits 27..26 are 00, and clears the flag for any other value.
- R5: The execute cycle of control state 0x00A copies data bits 3..0 into configuration bits 3..0 of the highest-priority unit (lowest index) whose full flag is high. It drives that flag low and leaves the other 28 bits of that unit unchanged.
- R6: Each further 0x00A execute goes to the next lower-priority empty unit. Units that are already full keep their word. Once all units are full, a 0x00A execute changes nothing.
- R7: The execute cycle of control state 0x00C sets every full flag high and leaves all configuration words unchanged.
- R8: `allFull` is high exactly when every full flag is low.
- R9: The pending control state persists across execute cycles, so repeated execute cycles repeat it. An execute cycle with any other control state (for example 0x0FF) has no effect.
- R10: Nothing changes in a cycle with `busStrobe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| busStrobe | input | 1 | Marks a bus cycle |
| addrValidN | input | 1 | High: instruction cycle; low: execute cycle |
| busData | input | 32 | Shared data bus |
| cfgOut | output | 128 | Configuration words, unit i at bits 32i+31..32i |
| fullN | output | 4 | Active-low full flag for each unit |
| hwMode | output | 4 | Hardware control mode flag for each unit |
| allFull | output | 1 | Bottom of the full chain: every unit full |

## Verification
Broadcast configuration writes use one value with bits 27..26 at 00 and one with them at 01. This separates the entry into hardware mode from the exit out of it, and confirms that every unit receives the whole word. A run of back-to-back page-number executes walks the chain down to all full and then goes past it. This shows target selection in priority order, shows that units already full are not touched, and shows that the write is ignored once nothing is empty. A clear followed by a partial re-enumeration shows that flags can be reused without disturbing page fields already written. A read-flagged instruction cycle, an unknown control state and unstrobed bus noise must each leave every output unchanged.

// File: rtl/cfg_enum_pkg.sv
package cfg_enum_pkg;
  localparam int OP_W = 12;
  localparam logic [OP_W-1:0] OP_NONE    = 12'h000;
  localparam logic [OP_W-1:0] OP_WR_CFG  = 12'h006;
  localparam logic [OP_W-1:0] OP_WR_PAGE = 12'h00A;
  localparam logic [OP_W-1:0] OP_CLR_FUL = 12'h00C;
  localparam int RD_BIT     = 13;
  localparam int MODE_HI    = 27;
  localparam int MODE_LO    = 26;
  localparam int LAST_BIT   = 25;

  typedef struct packed {
    logic loadCfg;
    logic writePage;
    logic clearFull;
  } ctrlStrobe_t;
endpackage

// File: rtl/cfg_enum_ctrl.sv
module cfg_enum_ctrl
  import cfg_enum_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busStrobe,
  input  logic              addrValidN,
  input  logic [DATA_W-1:0] busData,
  output logic [OP_W-1:0]   instrQ,
  output ctrlStrobe_t       strobes
);
  logic instrCycle;
  logic execCycle;

  assign instrCycle = busStrobe && addrValidN;
  assign execCycle  = busStrobe && !addrValidN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrQ <= OP_NONE;
    end else if (instrCycle && !busData[RD_BIT]) begin
      instrQ <= busData[OP_W-1:0];
    end
  end

  always_comb begin
    strobes = '0;
    if (execCycle) begin
      unique case (instrQ)
        OP_WR_CFG:  strobes.loadCfg   = 1'b1;
        OP_WR_PAGE: strobes.writePage = 1'b1;
        OP_CLR_FUL: strobes.clearFull = 1'b1;
        default:    strobes = '0;
      endcase
    end
  end
endmodule

// File: rtl/cfg_enum_unit.sv
module cfg_enum_unit
  import cfg_enum_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobes,
  input  logic [DATA_W-1:0] busData,
  input  logic              aboveFull,
  output logic              chainOut,
  output logic [DATA_W-1:0] cfgQ,
  output logic              fullNQ,
  output logic              hwModeQ
);
  localparam logic [DATA_W-1:0] CFG_RESET = DATA_W'(1) << LAST_BIT;

  logic isTarget;

  assign isTarget = aboveFull && fullNQ;
  assign chainOut = aboveFull && !fullNQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= CFG_RESET;
      hwModeQ <= 1'b0;
    end else if (strobes.loadCfg) begin
      cfgQ    <= busData;
      hwModeQ <= (busData[MODE_HI:MODE_LO] == 2'b00);
    end else if (strobes.writePage && isTarget) begin
      cfgQ[PAGE_W-1:0] <= busData[PAGE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullNQ <= 1'b1;
    end else if (strobes.clearFull) begin
      fullNQ <= 1'b1;
    end else if (strobes.writePage && isTarget) begin
      fullNQ <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_enum_array.sv
module cfg_enum_array
  import cfg_enum_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int DATA_W    = 32,
  parameter int PAGE_W    = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busStrobe,
  input  logic                        addrValidN,
  input  logic [DATA_W-1:0]           busData,
  output logic [NUM_UNITS*DATA_W-1:0] cfgOut,
  output logic [NUM_UNITS-1:0]        fullN,
  output logic [NUM_UNITS-1:0]        hwMode,
  output logic                        allFull
);
  logic [OP_W-1:0]    instrQ;
  ctrlStrobe_t        strobes;
  logic [NUM_UNITS:0] fullChain;

  cfg_enum_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .busStrobe  (busStrobe),
    .addrValidN (addrValidN),
    .busData    (busData),
    .instrQ     (instrQ),
    .strobes    (strobes)
  );

  assign fullChain[0] = 1'b1;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    cfg_enum_unit #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) unit_i (
      .clk       (clk),
      .rstN      (rstN),
      .strobes   (strobes),
      .busData   (busData),
      .aboveFull (fullChain[u]),
      .chainOut  (fullChain[u+1]),
      .cfgQ      (cfgOut[u*DATA_W +: DATA_W]),
      .fullNQ    (fullN[u]),
      .hwModeQ   (hwMode[u])
    );
  end

  assign allFull = fullChain[NUM_UNITS];
endmodule

// File: rtl/cfg_enum_chk.sv
module cfg_enum_chk
  import cfg_enum_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int DATA_W    = 32,
  parameter int PAGE_W    = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        busStrobe,
  input logic                        addrValidN,
  input logic [DATA_W-1:0]           busData,
  input logic [NUM_UNITS*DATA_W-1:0] cfgOut,
  input logic [NUM_UNITS-1:0]        fullN,
  input logic [NUM_UNITS-1:0]        hwMode,
  input logic                        allFull,
  input logic [OP_W-1:0]             instrQ
);
  logic [NUM_UNITS-1:0] fullMask;
  assign fullMask = ~fullN;

  AST_FULL_THERMO: assert property (@(posedge clk) disable iff (!rstN)
    (fullMask & (fullMask + NUM_UNITS'(1))) == '0); // R6

  AST_ONE_FILL: assert property (@(posedge clk) disable iff (!rstN)
    $countones($past(fullN) & ~fullN) <= 1); // R5

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !busStrobe |=> $stable(cfgOut) && $stable(fullN) && $stable(hwMode) && $stable(instrQ)); // R10

  AST_EXEC_KEEPS_INSTR: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe && !addrValidN |=> $stable(instrQ)); // R9

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe && !addrValidN && instrQ == OP_CLR_FUL |=> fullN == '1 && $stable(cfgOut)); // R7

  AST_ALLFULL_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    allFull |-> fullN == '0); // R8

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
    AST_PAGE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
      $fell(fullN[u]) |-> cfgOut[u*DATA_W +: PAGE_W] == $past(busData[PAGE_W-1:0])); // R5
  end
endmodule

bind cfg_enum_array cfg_enum_chk #(
  .NUM_UNITS(NUM_UNITS), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .busStrobe  (busStrobe),
  .addrValidN (addrValidN),
  .busData    (busData),
  .cfgOut     (cfgOut),
  .fullN      (fullN),
  .hwMode     (hwMode),
  .allFull    (allFull),
  .instrQ     (instrQ)
);

// File: tb/cfg_enum_array_tb.sv
module cfg_enum_array_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int DW = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b1;
  logic              busStrobe = 1'b0;
  logic              addrValidN = 1'b1;
  logic [DW-1:0]     busData = '0;
  logic [N*DW-1:0]   cfgOut;
  logic [N-1:0]      fullN;
  logic [N-1:0]      hwMode;
  logic              allFull;

  int errors = 0;
  int checks = 0;
  bit compareOn = 1'b0;
  bit done = 1'b0;
  string curReq = "R1";

  logic [DW-1:0] mCfg [N];
  bit            mFull [N];
  bit            mHw [N];
  int            mInstr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_enum_array #(.NUM_UNITS(N), .DATA_W(DW), .PAGE_W(4)) dut_i (
    .clk(clk), .rstN(rstN), .busStrobe(busStrobe), .addrValidN(addrValidN),
    .busData(busData), .cfgOut(cfgOut), .fullN(fullN), .hwMode(hwMode),
    .allFull(allFull)
  );

  task automatic modelReset();
    for (int i = 0; i < N; i++) begin
      mCfg[i] = 32'h0200_0000; mFull[i] = 1'b1; mHw[i] = 1'b0;
    end
    mInstr = 0;
  endtask

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compareAll(string req);
    bit anyEmpty = 1'b0;
    for (int i = 0; i < N; i++) begin
      check(req, $sformatf("cfg[%0d]", i), cfgOut[i*DW +: DW], mCfg[i]);
      check(req, $sformatf("fullN[%0d]", i), DW'(fullN[i]), DW'(mFull[i]));
      check(req, $sformatf("hwMode[%0d]", i), DW'(hwMode[i]), DW'(mHw[i]));
      if (mFull[i]) anyEmpty = 1'b1;
    end
    check("R8", "allFull", DW'(allFull), DW'(!anyEmpty));
  endtask

  always @(negedge clk) if (compareOn && !done) compareAll(curReq);

  task automatic busCycle(bit strobe, bit av, logic [DW-1:0] d);
    @(posedge clk);
    #1;
    busStrobe = strobe; addrValidN = av; busData = d;
    @(posedge clk);
    if (strobe) begin
      if (av) begin
        if (!d[13]) mInstr = int'(d[11:0]);
      end else begin
        case (mInstr)
          12'h006: for (int i = 0; i < N; i++) begin
            mCfg[i] = d; mHw[i] = (d[27:26] == 2'b00);
          end
          12'h00A: begin
            int t = -1;
            for (int i = 0; i < N; i++) if (t < 0 && mFull[i]) t = i;
            if (t >= 0) begin mCfg[t][3:0] = d[3:0]; mFull[t] = 1'b0; end
          end
          12'h00C: for (int i = 0; i < N; i++) mFull[i] = 1'b1;
          default: ;
        endcase
      end
    end
    #1;
    busStrobe = 1'b0; addrValidN = 1'b1; busData = '0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    modelReset();
    #1 rstN = 1'b0;
    repeat (5) @(posedge clk);
    #2;
    curReq = "R1"; compareOn = 1'b1;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (2) @(posedge clk);

    curReq = "R3"; busCycle(1, 1, 32'h0000_0006); busCycle(1, 0, 32'h1234_5670);
    curReq = "R4"; busCycle(1, 0, 32'h0400_00F0);
    busCycle(1, 0, 32'h03FF_FFF0);

    curReq = "R2"; busCycle(1, 1, 32'h0000_200A); busCycle(1, 0, 32'h0000_00A0);

    curReq = "R10"; busCycle(0, 0, 32'hFFFF_FFFF); busCycle(0, 1, 32'h0000_000C);

    curReq = "R5"; busCycle(1, 1, 32'h0000_000A); busCycle(1, 0, 32'hFFFF_FFF5);
    curReq = "R6"; busCycle(1, 0, 32'h0000_0009); busCycle(1, 0, 32'h0000_0003);
    busCycle(1, 0, 32'h0000_000E);
    busCycle(1, 0, 32'h0000_0007);

    curReq = "R9"; busCycle(1, 1, 32'h0000_00FF); busCycle(1, 0, 32'hDEAD_BEEF);

    curReq = "R7"; busCycle(1, 1, 32'h0000_000C); busCycle(1, 0, 32'h0000_0000);
    busCycle(1, 0, 32'h0000_0000);

    curReq = "R6"; busCycle(1, 1, 32'h0000_000A); busCycle(1, 0, 32'h0000_0001);
    busCycle(1, 0, 32'h0000_0002);

    repeat (2) @(posedge clk);
    #2;
    finishRun();
  end
endmodule